// File: doc/BRIEF.md
# Segment Address Translator With Mode-Selected Descriptor Loading

This block keeps six segment slots, numbered 0 to 5 (0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS). Each slot holds a cached base, a limit and a usable flag. A segment load writes one slot. How the slot is filled depends on the current mode. In the legacy modes the base is computed from the selector and no memory is touched. In the protected and 64-bit modes an 8-byte descriptor is fetched through a simple read port. For FS and GS only, the base can also be written directly through a side port.

Every access names a slot, an offset and an access size. The block returns the linear address one cycle later, or a fault if the access would cross the cached limit. Accesses use only the cached fields, so they cost no memory traffic. In 64-bit mode only FS and GS still add a base, and no limit is enforced. When the effective base is zero, the adder is bypassed and the offset passes straight through.

Top module: `seg_translator`

## Requirements
- R1: After reset the block is in mode 0 (real). Slot CS has base 0xFFFF0000 and every other slot has base 0. Every limit is 0xFFFF, every slot is usable, and `ld_ack_o`, `mem_rd_o`, `lin_valid_o` and `fault_o` are low.
- R2: In modes 0 (real), 1 (virtual-8086) and 2 (system management), a load sets the slot's base to the selector times 16 and its limit to 0xFFFF, and marks the slot usable. No memory read is issued. `ld_ack_o` pulses for one cycle, in the cycle after the request is taken.
- R3: In modes 3 (16-bit protected), 4 (32-bit protected) and 5 (64-bit), a load asserts `mem_rd_o` with `mem_addr_o` equal to `tbl_base_i + (sel & ~7)`. The read stays asserted at a stable address until `mem_rvalid_i` is seen. The slot then takes its base from descriptor bits [31:0] and its limit from bits [55:32], and `ld_ack_o` pulses in the following cycle.
- R4: In mode 3 only bits [47:32] of the descriptor form the limit, so a segment spans 1 to 65536 bytes.
- R5: In modes 3, 4 and 5, a selector with bits [15:3] equal to zero, loaded into ES, DS, FS or GS, issues no memory read. It makes the slot unusable with base 0 and limit 0. In modes other than 5, any later access through that slot faults.
- R6: In every mode except 5, an access faults when its last byte exceeds the limit. The last byte is the offset plus the size minus one, where size code 0/1/2/3 means 1/2/4/8 bytes and the sum is taken without wrap.
- R7: The result appears in the cycle after `acc_valid_i`. `lin_valid_o` and `fault_o` are never high together. On a fault `lin_addr_o` is 0. Without an access, both outputs are low.
- R8: In mode 5, slots 0 to 3 use an effective base of zero, and no access faults.
- R9: In mode 5, FS and GS still add their cached base.
- R10: When `bw_en_i` is high, the base of FS (`bw_gs_i`=0) or GS (`bw_gs_i`=1) is written with `bw_base_i` in any mode. The limit and usable flag are unchanged. This write takes priority over a load finishing on the same slot in the same cycle.
- R11: The linear address is the effective base plus the offset, modulo 2^32. When the effective base is zero, `byp_o` is high with a valid result and the address equals the offset.
- R12: Accesses never drive the memory read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Current mode code (0..5) |
| tbl_base_i | input | 32 | Byte address of the descriptor table |
| ld_req_i | input | 1 | Segment load request, held until acknowledged |
| ld_seg_i | input | 3 | Slot to load |
| ld_sel_i | input | 16 | Selector value |
| ld_ack_o | output | 1 | One-cycle load completion |
| mem_rd_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor address |
| mem_rvalid_i | input | 1 | Descriptor data valid strobe |
| mem_rdata_i | input | 56 | Descriptor: base [31:0], limit [55:32] |
| bw_en_i | input | 1 | Direct base write enable |
| bw_gs_i | input | 1 | Direct write target: 0 FS, 1 GS |
| bw_base_i | input | 32 | Direct base value |
| acc_valid_i | input | 1 | Access strobe |
| acc_seg_i | input | 3 | Slot used by the access |
| acc_ofs_i | input | 32 | Access offset |
| acc_size_i | input | 2 | Size code: 1, 2, 4 or 8 bytes |
| lin_valid_o | output | 1 | Linear address valid |
| lin_addr_o | output | 32 | Linear address |
| fault_o | output | 1 | Limit or unusable-segment fault |
| byp_o | output | 1 | Adder bypassed because the effective base is zero |

## Verification
On every cycle the assertions check the shape of the result:

- a result follows each access, and nothing appears without one;
- `lin_valid_o` and `fault_o` are exclusive, and the address reads zero on a fault;
- mode 5 never faults;
- a bypassed address equals the offset;
- a descriptor read holds its address until the data strobe, then ends in a single acknowledge.

Only the bench's scenarios can show that each load path leaves the right base and limit in the right slot. The same holds for the exact limit boundary at every access size, the 16-bit truncation of the limit, null-selector handling and direct-write priority.

// File: rtl/seg_pkg.sv
`timescale 1ns/1ps
package seg_pkg;

   localparam logic [2:0] MD_REAL   = 3'd0;
   localparam logic [2:0] MD_V86    = 3'd1;
   localparam logic [2:0] MD_SMM    = 3'd2;
   localparam logic [2:0] MD_PROT16 = 3'd3;
   localparam logic [2:0] MD_PROT32 = 3'd4;
   localparam logic [2:0] MD_LONG   = 3'd5;

   localparam int SLOT_ES = 0;
   localparam int SLOT_CS = 1;
   localparam int SLOT_SS = 2;
   localparam int SLOT_DS = 3;
   localparam int SLOT_FS = 4;
   localparam int SLOT_GS = 5;

   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_FETCH = 2'd1,
      LD_ACK   = 2'd2
   } ld_state_e;

   function automatic logic is_table_mode(input logic [2:0] m);
      return (m == MD_PROT16) || (m == MD_PROT32) || (m == MD_LONG);
   endfunction

   function automatic logic keeps_base_long(input int slot);
      return (slot == SLOT_FS) || (slot == SLOT_GS);
   endfunction

endpackage

// File: rtl/seg_regfile.sv
`timescale 1ns/1ps
module seg_regfile
   import seg_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                NSEG        = 6,
   parameter int                SEG_W       = 3,
   parameter logic [ADDR_W-1:0] CS_RST_BASE = 'hFFFF_0000,
   parameter logic [ADDR_W-1:0] RST_LIMIT   = 'h0000_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_seg,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [ADDR_W-1:0] wr_limit,
   input  logic              wr_usable,
   input  logic              bw_en,
   input  logic              bw_gs,
   input  logic [ADDR_W-1:0] bw_base,
   input  logic [SEG_W-1:0]  rd_seg,
   output logic [ADDR_W-1:0] rd_base,
   output logic [ADDR_W-1:0] rd_limit,
   output logic              rd_usable
);

   logic [ADDR_W-1:0] base_a   [NSEG];
   logic [ADDR_W-1:0] limit_a  [NSEG];
   logic              usable_a [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_slot
      localparam logic [ADDR_W-1:0] BASE_RST = (g == SLOT_CS) ? CS_RST_BASE : '0;
      logic [ADDR_W-1:0] base_q;
      logic [ADDR_W-1:0] limit_q;
      logic              usable_q;
      logic              hit;

      assign hit = wr_en && (wr_seg == SEG_W'(g));

      if (keeps_base_long(g)) begin : g_direct
         logic bw_hit;
         assign bw_hit = bw_en && (bw_gs == (g == SLOT_GS));
         always_ff @(posedge clk) begin
            if (!rst_n)      base_q <= BASE_RST;
            else if (bw_hit) base_q <= bw_base;
            else if (hit)    base_q <= wr_base;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)   base_q <= BASE_RST;
            else if (hit) base_q <= wr_base;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            limit_q  <= RST_LIMIT;
            usable_q <= 1'b1;
         end else if (hit) begin
            limit_q  <= wr_limit;
            usable_q <= wr_usable;
         end
      end

      assign base_a[g]   = base_q;
      assign limit_a[g]  = limit_q;
      assign usable_a[g] = usable_q;
   end

   always_comb begin
      rd_base   = '0;
      rd_limit  = '0;
      rd_usable = 1'b0;
      for (int i = 0; i < NSEG; i++) begin
         if (rd_seg == SEG_W'(i)) begin
            rd_base   = base_a[i];
            rd_limit  = limit_a[i];
            rd_usable = usable_a[i];
         end
      end
   end

endmodule

// File: rtl/seg_loader.sv
`timescale 1ns/1ps
module seg_loader
   import seg_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                LIM_W      = 24,
   parameter int                SEL_W      = 16,
   parameter int                SEG_W      = 3,
   parameter logic [ADDR_W-1:0] REAL_LIMIT = 'h0000_FFFF,
   localparam int               DESC_W     = ADDR_W + LIM_W,
   localparam int               IDX_LSB    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic [ADDR_W-1:0] tbl_base_i,
   input  logic              ld_req_i,
   input  logic [SEG_W-1:0]  ld_seg_i,
   input  logic [SEL_W-1:0]  ld_sel_i,
   output logic              ld_ack_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [DESC_W-1:0] mem_rdata_i,
   output logic              wr_en_o,
   output logic [SEG_W-1:0]  wr_seg_o,
   output logic [ADDR_W-1:0] wr_base_o,
   output logic [ADDR_W-1:0] wr_limit_o,
   output logic              wr_usable_o
);

   ld_state_e         state_q, state_d;
   logic [SEG_W-1:0]  seg_q;
   logic              p16_q;
   logic [ADDR_W-1:0] addr_q;
   logic              accept_tbl;
   logic              null_sel;
   logic              data_slot;
   logic [ADDR_W-1:0] entry_addr;
   logic [ADDR_W-1:0] shifted_base;
   logic [LIM_W-1:0]  desc_lim;

   assign null_sel     = (ld_sel_i[SEL_W-1:IDX_LSB] == '0);
   assign data_slot    = (ld_seg_i != SEG_W'(SLOT_CS)) && (ld_seg_i != SEG_W'(SLOT_SS));
   assign entry_addr   = tbl_base_i + ADDR_W'({ld_sel_i[SEL_W-1:IDX_LSB], 3'b000});
   assign shifted_base = ADDR_W'({ld_sel_i, 4'b0000});
   assign desc_lim     = mem_rdata_i[ADDR_W +: LIM_W];

   always_comb begin
      state_d     = state_q;
      accept_tbl  = 1'b0;
      wr_en_o     = 1'b0;
      wr_seg_o    = ld_seg_i;
      wr_base_o   = '0;
      wr_limit_o  = '0;
      wr_usable_o = 1'b0;
      case (state_q)
         LD_IDLE: begin
            if (ld_req_i) begin
               if (!is_table_mode(mode_i)) begin
                  wr_en_o     = 1'b1;
                  wr_base_o   = shifted_base;
                  wr_limit_o  = REAL_LIMIT;
                  wr_usable_o = 1'b1;
                  state_d     = LD_ACK;
               end else if (null_sel && data_slot) begin
                  wr_en_o = 1'b1;
                  state_d = LD_ACK;
               end else begin
                  accept_tbl = 1'b1;
                  state_d    = LD_FETCH;
               end
            end
         end
         LD_FETCH: begin
            wr_seg_o = seg_q;
            if (mem_rvalid_i) begin
               wr_en_o     = 1'b1;
               wr_base_o   = mem_rdata_i[ADDR_W-1:0];
               wr_limit_o  = p16_q ? ADDR_W'(desc_lim[15:0]) : ADDR_W'(desc_lim);
               wr_usable_o = 1'b1;
               state_d     = LD_ACK;
            end
         end
         LD_ACK:  state_d = LD_IDLE;
         default: state_d = LD_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LD_IDLE;
         seg_q   <= '0;
         p16_q   <= 1'b0;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept_tbl) begin
            seg_q  <= ld_seg_i;
            p16_q  <= (mode_i == MD_PROT16);
            addr_q <= entry_addr;
         end
      end
   end

   assign ld_ack_o   = (state_q == LD_ACK);
   assign mem_rd_o   = (state_q == LD_FETCH);
   assign mem_addr_o = addr_q;

endmodule

// File: rtl/seg_xlate.sv
`timescale 1ns/1ps
module seg_xlate
   import seg_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SEG_W       = 3,
   parameter bit BYPASS_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic              acc_valid_i,
   input  logic [SEG_W-1:0]  acc_seg_i,
   input  logic [ADDR_W-1:0] acc_ofs_i,
   input  logic [1:0]        acc_size_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] limit_i,
   input  logic              usable_i,
   output logic              lin_valid_o,
   output logic [ADDR_W-1:0] lin_addr_o,
   output logic              fault_o,
   output logic              byp_o
);

   logic              long_md;
   logic              keep_base;
   logic [ADDR_W-1:0] eff_base;
   logic [ADDR_W:0]   last_byte;
   logic              over;
   logic              flt;
   logic [ADDR_W-1:0] lin_d;
   logic              byp_d;

   assign long_md   = (mode_i == MD_LONG);
   assign keep_base = (acc_seg_i == SEG_W'(SLOT_FS)) || (acc_seg_i == SEG_W'(SLOT_GS));
   assign eff_base  = (long_md && !keep_base) ? '0 : base_i;
   assign last_byte = {1'b0, acc_ofs_i} + ((ADDR_W+1)'(1) << acc_size_i) - (ADDR_W+1)'(1);
   assign over      = last_byte > {1'b0, limit_i};
   assign flt       = !long_md && (!usable_i || over);

   if (BYPASS_ZERO) begin : g_bypass
      assign byp_d = (eff_base == '0);
      assign lin_d = byp_d ? acc_ofs_i : eff_base + acc_ofs_i;
   end else begin : g_always_add
      assign byp_d = 1'b0;
      assign lin_d = eff_base + acc_ofs_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lin_valid_o <= 1'b0;
         fault_o     <= 1'b0;
         lin_addr_o  <= '0;
         byp_o       <= 1'b0;
      end else begin
         lin_valid_o <= acc_valid_i && !flt;
         fault_o     <= acc_valid_i && flt;
         lin_addr_o  <= (acc_valid_i && !flt) ? lin_d : '0;
         byp_o       <= acc_valid_i && !flt && byp_d;
      end
   end

endmodule

// File: rtl/seg_translator.sv
`timescale 1ns/1ps
module seg_translator
   import seg_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                LIM_W       = 24,
   parameter int                SEL_W       = 16,
   parameter int                NSEG        = 6,
   parameter logic [ADDR_W-1:0] CS_RST_BASE = 'hFFFF_0000,
   parameter logic [ADDR_W-1:0] RST_LIMIT   = 'h0000_FFFF,
   parameter bit                BYPASS_ZERO = 1'b1,
   localparam int               SEG_W       = $clog2(NSEG),
   localparam int               DESC_W      = ADDR_W + LIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_i,
   input  logic [ADDR_W-1:0] tbl_base_i,
   input  logic              ld_req_i,
   input  logic [SEG_W-1:0]  ld_seg_i,
   input  logic [SEL_W-1:0]  ld_sel_i,
   output logic              ld_ack_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [DESC_W-1:0] mem_rdata_i,
   input  logic              bw_en_i,
   input  logic              bw_gs_i,
   input  logic [ADDR_W-1:0] bw_base_i,
   input  logic              acc_valid_i,
   input  logic [SEG_W-1:0]  acc_seg_i,
   input  logic [ADDR_W-1:0] acc_ofs_i,
   input  logic [1:0]        acc_size_i,
   output logic              lin_valid_o,
   output logic [ADDR_W-1:0] lin_addr_o,
   output logic              fault_o,
   output logic              byp_o
);

   if (NSEG < SLOT_GS + 1) begin : g_bad_nseg
      $error("NSEG must cover the FS and GS slots");
   end
   if (SEL_W + 4 > ADDR_W) begin : g_bad_sel
      $error("shifted selector does not fit the address width");
   end
   if (LIM_W < 16 || LIM_W > ADDR_W) begin : g_bad_lim
      $error("LIM_W must lie between 16 and ADDR_W");
   end

   logic              wr_en;
   logic [SEG_W-1:0]  wr_seg;
   logic [ADDR_W-1:0] wr_base;
   logic [ADDR_W-1:0] wr_limit;
   logic              wr_usable;
   logic [ADDR_W-1:0] rd_base;
   logic [ADDR_W-1:0] rd_limit;
   logic              rd_usable;

   seg_loader #(
      .ADDR_W     (ADDR_W),
      .LIM_W      (LIM_W),
      .SEL_W      (SEL_W),
      .SEG_W      (SEG_W),
      .REAL_LIMIT (RST_LIMIT)
   ) u_loader (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (mode_i),
      .tbl_base_i   (tbl_base_i),
      .ld_req_i     (ld_req_i),
      .ld_seg_i     (ld_seg_i),
      .ld_sel_i     (ld_sel_i),
      .ld_ack_o     (ld_ack_o),
      .mem_rd_o     (mem_rd_o),
      .mem_addr_o   (mem_addr_o),
      .mem_rvalid_i (mem_rvalid_i),
      .mem_rdata_i  (mem_rdata_i),
      .wr_en_o      (wr_en),
      .wr_seg_o     (wr_seg),
      .wr_base_o    (wr_base),
      .wr_limit_o   (wr_limit),
      .wr_usable_o  (wr_usable)
   );

   seg_regfile #(
      .ADDR_W      (ADDR_W),
      .NSEG        (NSEG),
      .SEG_W       (SEG_W),
      .CS_RST_BASE (CS_RST_BASE),
      .RST_LIMIT   (RST_LIMIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_seg    (wr_seg),
      .wr_base   (wr_base),
      .wr_limit  (wr_limit),
      .wr_usable (wr_usable),
      .bw_en     (bw_en_i),
      .bw_gs     (bw_gs_i),
      .bw_base   (bw_base_i),
      .rd_seg    (acc_seg_i),
      .rd_base   (rd_base),
      .rd_limit  (rd_limit),
      .rd_usable (rd_usable)
   );

   seg_xlate #(
      .ADDR_W      (ADDR_W),
      .SEG_W       (SEG_W),
      .BYPASS_ZERO (BYPASS_ZERO)
   ) u_xlate (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .acc_valid_i (acc_valid_i),
      .acc_seg_i   (acc_seg_i),
      .acc_ofs_i   (acc_ofs_i),
      .acc_size_i  (acc_size_i),
      .base_i      (rd_base),
      .limit_i     (rd_limit),
      .usable_i    (rd_usable),
      .lin_valid_o (lin_valid_o),
      .lin_addr_o  (lin_addr_o),
      .fault_o     (fault_o),
      .byp_o       (byp_o)
   );

endmodule

// File: rtl/seg_translator_chk.sv
`timescale 1ns/1ps
module seg_translator_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode_i,
   input logic              ld_req_i,
   input logic              ld_ack_o,
   input logic              mem_rd_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_rvalid_i,
   input logic              acc_valid_i,
   input logic [ADDR_W-1:0] acc_ofs_i,
   input logic              lin_valid_o,
   input logic [ADDR_W-1:0] lin_addr_o,
   input logic              fault_o,
   input logic              byp_o
);

   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      lin_valid_o |-> !fault_o);

   a_r7_suppress: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> (lin_addr_o == '0));

   a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid_i |=> (lin_valid_o || fault_o));

   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid_i |=> !(lin_valid_o || fault_o));

   a_r8_long_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && mode_i == 3'd5) |=> !fault_o);

   a_r11_bypass_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_valid_o && byp_o) |-> (lin_addr_o == $past(acc_ofs_i)));

   a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && !mem_rvalid_i) |=> (mem_rd_o && $stable(mem_addr_o)));

   a_r3_read_done: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && mem_rvalid_i) |=> (ld_ack_o && !mem_rd_o));

   a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ack_o |=> !ld_ack_o);

   a_r2_ack_requested: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ld_ack_o) |-> ($past(ld_req_i) || $past(mem_rd_o)));

endmodule

bind seg_translator seg_translator_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_i),
   .ld_req_i     (ld_req_i),
   .ld_ack_o     (ld_ack_o),
   .mem_rd_o     (mem_rd_o),
   .mem_addr_o   (mem_addr_o),
   .mem_rvalid_i (mem_rvalid_i),
   .acc_valid_i  (acc_valid_i),
   .acc_ofs_i    (acc_ofs_i),
   .lin_valid_o  (lin_valid_o),
   .lin_addr_o   (lin_addr_o),
   .fault_o      (fault_o),
   .byp_o        (byp_o)
);

// File: tb/tb_seg_translator.sv
`timescale 1ns/1ps
module tb_seg_translator;

   localparam logic [31:0] TBL = 32'h0010_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_i = 3'd0;
   logic        ld_req_i = 1'b0;
   logic [2:0]  ld_seg_i = '0;
   logic [15:0] ld_sel_i = '0;
   logic        ld_ack_o;
   logic        mem_rd_o;
   logic [31:0] mem_addr_o;
   logic        mem_rvalid_i = 1'b0;
   logic [55:0] mem_rdata_i = '0;
   logic        bw_en_i = 1'b0;
   logic        bw_gs_i = 1'b0;
   logic [31:0] bw_base_i = '0;
   logic        acc_valid_i = 1'b0;
   logic [2:0]  acc_seg_i = '0;
   logic [31:0] acc_ofs_i = '0;
   logic [1:0]  acc_size_i = '0;
   logic        lin_valid_o;
   logic [31:0] lin_addr_o;
   logic        fault_o;
   logic        byp_o;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   logic [31:0] m_base [6];
   logic [31:0] m_lim  [6];
   bit          m_use  [6];

   always #2.5 clk = ~clk;

   seg_translator dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tbl_base_i(TBL),
      .ld_req_i(ld_req_i), .ld_seg_i(ld_seg_i), .ld_sel_i(ld_sel_i), .ld_ack_o(ld_ack_o),
      .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
      .mem_rdata_i(mem_rdata_i), .bw_en_i(bw_en_i), .bw_gs_i(bw_gs_i), .bw_base_i(bw_base_i),
      .acc_valid_i(acc_valid_i), .acc_seg_i(acc_seg_i), .acc_ofs_i(acc_ofs_i),
      .acc_size_i(acc_size_i), .lin_valid_o(lin_valid_o), .lin_addr_o(lin_addr_o),
      .fault_o(fault_o), .byp_o(byp_o)
   );

   task automatic check(input string req, input string what, input logic [63:0] act,
                        input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [55:0] desc_at(input logic [31:0] a);
      return {8'h02, a[15:0], a[15:0], 16'h0300};
   endfunction

   task automatic access(input int s, input logic [31:0] ofs, input logic [1:0] sz,
                         input string req);
      bit          lng;
      logic [31:0] eb;
      logic [32:0] last;
      bit          ef;
      logic [31:0] ea;
      lng  = (mode_i == 3'd5);
      eb   = (lng && s < 4) ? 32'h0 : m_base[s];
      last = {1'b0, ofs} + (33'd1 << sz) - 33'd1;
      ef   = !lng && (!m_use[s] || last > {1'b0, m_lim[s]});
      ea   = ef ? 32'h0 : eb + ofs;
      @(negedge clk);
      acc_valid_i = 1'b1; acc_seg_i = 3'(s); acc_ofs_i = ofs; acc_size_i = sz;
      @(negedge clk);
      acc_valid_i = 1'b0;
      check(req, "fault", 64'(fault_o), 64'(ef));
      check(req, "lin_valid", 64'(lin_valid_o), 64'(!ef));
      check(req, "lin_addr", 64'(lin_addr_o), 64'(ea));
      check(req, "bypass", 64'(byp_o), 64'(!ef && eb == 32'h0));
      check("R12", "mem_rd during access", 64'(mem_rd_o), 64'd0);
   endtask

   task automatic sweep(input int s, input string req);
      for (int sz = 0; sz < 4; sz++)
         for (int d = -9; d <= 1; d++)
            access(s, m_lim[s] + 32'(d), 2'(sz), req);
   endtask

   task automatic load(input int s, input logic [15:0] sel, input int dly, input string req);
      bit          tbl, nul, saw, got;
      int          w;
      logic [31:0] ea;
      logic [55:0] dsc;
      tbl = (mode_i >= 3'd3 && mode_i <= 3'd5);
      nul = (sel[15:3] == 13'd0) && s != 1 && s != 2;
      ea  = TBL + {16'h0, sel[15:3], 3'b000};
      dsc = desc_at(ea);
      saw = 1'b0; got = 1'b0; w = 0;
      @(negedge clk);
      ld_req_i = 1'b1; ld_seg_i = 3'(s); ld_sel_i = sel;
      for (int k = 0; k < 40 && !got; k++) begin
         @(negedge clk);
         mem_rvalid_i = 1'b0;
         if (ld_ack_o) got = 1'b1;
         else if (mem_rd_o) begin
            if (!saw) check(req, "descriptor address", 64'(mem_addr_o), 64'(ea));
            saw = 1'b1;
            if (w >= dly) begin
               mem_rvalid_i = 1'b1; mem_rdata_i = dsc;
            end
            w++;
         end
      end
      ld_req_i = 1'b0;
      check(req, "load acknowledged", 64'(got), 64'd1);
      check(req, "memory read issued", 64'(saw), 64'(tbl && !nul));
      if (!tbl) begin
         m_base[s] = {12'h0, sel, 4'h0}; m_lim[s] = 32'hFFFF; m_use[s] = 1'b1;
      end else if (nul) begin
         m_base[s] = 32'h0; m_lim[s] = 32'h0; m_use[s] = 1'b0;
      end else begin
         m_base[s] = dsc[31:0];
         m_lim[s]  = (mode_i == 3'd3) ? {16'h0, dsc[47:32]} : {8'h0, dsc[55:32]};
         m_use[s]  = 1'b1;
      end
   endtask

   task automatic base_write(input bit gs, input logic [31:0] b);
      @(negedge clk);
      bw_en_i = 1'b1; bw_gs_i = gs; bw_base_i = b;
      @(negedge clk);
      bw_en_i = 1'b0;
      m_base[gs ? 5 : 4] = b;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 6; i++) begin
         m_base[i] = (i == 1) ? 32'hFFFF_0000 : 32'h0;
         m_lim[i] = 32'hFFFF; m_use[i] = 1'b1;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "ld_ack", 64'(ld_ack_o), 64'd0);
      check("R1", "mem_rd", 64'(mem_rd_o), 64'd0);
      check("R1", "lin_valid", 64'(lin_valid_o), 64'd0);
      check("R1", "fault", 64'(fault_o), 64'd0);
      for (int s = 0; s < 6; s++) access(s, 32'h10, 2'd0, "R1");
      access(1, 32'hFFFF, 2'd1, "R1");
      // R7: quiet cycle after access
      @(negedge clk);
      check("R7", "idle valid", 64'(lin_valid_o | fault_o), 64'd0);

      // R2: computed loads in modes 0, 1, 2
      for (int md = 0; md < 3; md++) begin
         mode_i = 3'(md);
         for (int s = 0; s < 6; s++) begin
            load(s, 16'h1234 + 16'(s * 16'h0111) + 16'(md), 0, "R2");
            access(s, 32'h0042, 2'd2, "R2");
         end
      end
      mode_i = 3'd0;
      for (int s = 0; s < 6; s++) sweep(s, "R6");

      // R10: direct base write in real mode keeps limit
      base_write(1'b0, 32'h00AB_C000);
      access(4, 32'h20, 2'd0, "R10");
      access(4, 32'h1_0000, 2'd0, "R10");

      // R3: table loads in mode 4 with varying latency
      mode_i = 3'd4;
      for (int s = 0; s < 6; s++) begin
         load(s, 16'h0018 + 16'(s * 8) + 16'(s % 4), s % 3, "R3");
         sweep(s, "R6");
      end
      // R4: 16-bit protected mode truncates the limit
      mode_i = 3'd3;
      for (int s = 0; s < 6; s++) begin
         load(s, 16'h0400 + 16'(s * 16'h0108), 1, "R4");
         sweep(s, "R4");
      end
      // R5: null selector into a data slot; CS still fetches entry 0
      mode_i = 3'd4;
      load(3, 16'h0003, 0, "R5");
      access(3, 32'h0, 2'd0, "R5");
      load(1, 16'h0000, 2, "R5");
      access(1, 32'h10, 2'd0, "R5");

      // R8, R9: 64-bit mode
      mode_i = 3'd5;
      load(4, 16'h0050, 1, "R9");
      load(0, 16'h0001, 0, "R5");
      for (int s = 0; s < 6; s++) begin
         access(s, 32'hFFFF_FFF8, 2'd3, "R8");
         access(s, 32'h0012_3456, 2'd2, "R9");
      end
      // R10: direct write to GS in 64-bit mode, then R11 wrap
      base_write(1'b1, 32'hF000_0000);
      access(5, 32'h2000_0010, 2'd0, "R10");
      access(5, 32'h1000_0004, 2'd1, "R11");
      base_write(1'b0, 32'h0);
      access(4, 32'h0000_7777, 2'd0, "R11");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule